// File: doc/BRIEF.md
# CSR Instruction Execute Unit

This unit executes the three control-register access instructions of a processor pipeline: a plain read, a full write that swaps a general-purpose register with a control register, and a masked exchange. It sits between the operand-read stage and write-back. It takes the instruction word, the current privilege, and the two general-purpose operands the pipeline has fetched. It drives one port of the control-register file, with an address, a write enable and write data. From that port it takes back read data plus two status bits: whether the register exists, and whether it is read-only.

In the same cycle as the register-file write, the unit decides whether the instruction commits or faults. One cycle later it presents either a write-back to the destination register or an exception code, never both. It also presents a pipeline-refresh request when a committed write has touched a register that changes the execution context.

The control-register storage, the general-purpose register file and exception vectoring live outside this block.

Top module: `csr_exec_unit`

## Requirements
- R1: An instruction belongs to this unit only when `insn_valid` is high and `insn[31:24]` equals 8'h04. The register number is `insn[23:10]` and always appears on `csr_addr`. The selector/mask index is `insn[9:5]` and the destination index is `insn[4:0]`. Any other word causes no register write, no write-back, no exception and no refresh.
- R2: Selector 0 is a read. It never writes the control register, and rd receives the value on `csr_rdata`.
- R3: Selector 1 is a write. `csr_wdata` equals `rd_value` with `csr_we` high, and rd receives the value read before the write.
- R4: Any selector of 2 or more is an exchange with mask `rj_value`. The new value is (`rd_value` AND mask) OR (old AND NOT mask), and rd receives the old value.
- R5: When `user_mode` is high, every operation of the group raises exception code 6'h0E. It does not write the control register and does not write back.
- R6: When `csr_defined` is low, no write reaches the register, rd receives zero, and no exception is raised.
- R7: A write or exchange to a register with `csr_readonly` high raises exception code 6'h0D with no register write and no write-back. A read of such a register completes normally.
- R8: `refresh_req` is raised, one cycle after the access, only for a committed write or exchange to register number 0x000, 0x002, 0x005 or 0x018. Reads never raise it.
- R9: A write-back to index 0 is always dropped (`wb_en` stays low). The register-file side of the operation still takes place.
- R10: `csr_addr`, `csr_we` and `csr_wdata` are valid in the cycle of the instruction. `wb_en`, `wb_idx`, `wb_data`, `exc_valid`, `exc_code` and `refresh_req` are registered and appear on the next cycle, for that one cycle only. `exc_valid` and `wb_en` are never both high. Every flag is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| user_mode | input | 1 | Current privilege is user level |
| rd_value | input | DATA_W | Value of the general-purpose register named by the destination index |
| rj_value | input | DATA_W | Value of the general-purpose register named by the selector index (mask) |
| csr_rdata | input | DATA_W | Current value of the addressed control register |
| csr_defined | input | 1 | Addressed control register exists |
| csr_readonly | input | 1 | Addressed control register is read-only |
| csr_addr | output | 14 | Control-register number |
| csr_we | output | 1 | Control-register write enable |
| csr_wdata | output | DATA_W | Control-register write data |
| wb_en | output | 1 | Destination write-back enable (registered) |
| wb_idx | output | 5 | Destination register index (registered) |
| wb_data | output | DATA_W | Destination write-back value (registered) |
| exc_valid | output | 1 | Exception strobe (registered) |
| exc_code | output | 6 | Exception code (registered) |
| refresh_req | output | 1 | Pipeline refresh request (registered) |

## Verification
The bench aims at the points where the fault checks overlap. A user-level access to an undefined or read-only register must still report the privilege fault. A design that ordered the checks wrongly would return zero or report the illegal code instead. An exchange with an all-zero mask must rewrite the old value unchanged, and one with an all-ones mask must behave like a write. An inverted mask term would corrupt both cases.

Reads of registers on the refresh list, and writes to registers close to it, catch a design that raises refresh on any access or matches the wrong numbers. Writes with destination index 0 catch a design that drops the register write together with the write-back, or that lets the write-back through. Selector values 0, 1 and 2 expose any mixing-up of the opcode decode with the mask index.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

  localparam int INSN_W    = 32;
  localparam int CSR_NUM_W = 14;
  localparam int REG_IDX_W = 5;
  localparam int EXC_W     = 6;

  localparam logic [7:0]       GROUP_TAG   = 8'h04;
  localparam logic [EXC_W-1:0] EXC_NONE    = 6'h00;
  localparam logic [EXC_W-1:0] EXC_ILLEGAL = 6'h0D;
  localparam logic [EXC_W-1:0] EXC_PRIV    = 6'h0E;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_XCHG  = 2'd3
  } csr_op_e;

endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_exec_pkg::*;
(
  input  logic                 insn_valid,
  input  logic [INSN_W-1:0]    insn,
  output csr_op_e              op,
  output logic [CSR_NUM_W-1:0] csr_num,
  output logic [REG_IDX_W-1:0] rj_idx,
  output logic [REG_IDX_W-1:0] rd_idx
);

  logic in_group;

  assign csr_num  = insn[23:10];
  assign rj_idx   = insn[9:5];
  assign rd_idx   = insn[4:0];
  assign in_group = insn_valid && (insn[31:24] == GROUP_TAG);

  // selector field doubles as opcode: 0 read, 1 write, otherwise exchange
  always_comb begin
    op = OP_NONE;
    if (in_group) begin
      if (rj_idx == '0)
        op = OP_READ;
      else if (rj_idx == REG_IDX_W'(1))
        op = OP_WRITE;
      else
        op = OP_XCHG;
    end
  end

endmodule

// File: rtl/csr_bit_merge.sv
module csr_bit_merge #(
  parameter int DATA_W = 64
) (
  input  logic              exchange,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] mask_val,
  output logic [DATA_W-1:0] new_val
);

  // per bit: keep the old bit only for an exchange with a clear mask bit
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign new_val[b] = (exchange && !mask_val[b]) ? old_val[b] : src_val[b];
  end

endmodule

// File: rtl/csr_refresh_match.sv
module csr_refresh_match #(
  parameter int                         NUM_W     = 14,
  parameter int                         N_ENTRIES = 4,
  parameter logic [N_ENTRIES*NUM_W-1:0] LIST      = '0
) (
  input  logic [NUM_W-1:0] csr_num,
  output logic             hit
);

  logic [N_ENTRIES-1:0] entry_hit;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    assign entry_hit[e] = (csr_num == LIST[e*NUM_W +: NUM_W]);
  end

  assign hit = |entry_hit;

endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
  import csr_exec_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int N_REFRESH = 4,
  parameter logic [N_REFRESH*CSR_NUM_W-1:0] REFRESH_LIST =
    {14'h018, 14'h005, 14'h002, 14'h000}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 insn_valid,
  input  logic [INSN_W-1:0]    insn,
  input  logic                 user_mode,
  input  logic [DATA_W-1:0]    rd_value,
  input  logic [DATA_W-1:0]    rj_value,
  input  logic [DATA_W-1:0]    csr_rdata,
  input  logic                 csr_defined,
  input  logic                 csr_readonly,
  output logic [CSR_NUM_W-1:0] csr_addr,
  output logic                 csr_we,
  output logic [DATA_W-1:0]    csr_wdata,
  output logic                 wb_en,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [DATA_W-1:0]    wb_data,
  output logic                 exc_valid,
  output logic [EXC_W-1:0]     exc_code,
  output logic                 refresh_req
);

  localparam int SYNC_STAGES = 2;

  // ---------------- reset release synchroniser ----------------
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  // ---------------- decode ----------------
  csr_op_e              op;
  logic [CSR_NUM_W-1:0] csr_num;
  logic [REG_IDX_W-1:0] rj_idx;
  logic [REG_IDX_W-1:0] rd_idx;

  csr_op_decode u_decode (
    .insn_valid (insn_valid),
    .insn       (insn),
    .op         (op),
    .csr_num    (csr_num),
    .rj_idx     (rj_idx),
    .rd_idx     (rd_idx)
  );

  // ---------------- merge and refresh lookup ----------------
  logic [DATA_W-1:0] merged;
  logic              refresh_hit;

  csr_bit_merge #(.DATA_W(DATA_W)) u_merge (
    .exchange (op == OP_XCHG),
    .old_val  (csr_rdata),
    .src_val  (rd_value),
    .mask_val (rj_value),
    .new_val  (merged)
  );

  csr_refresh_match #(
    .NUM_W     (CSR_NUM_W),
    .N_ENTRIES (N_REFRESH),
    .LIST      (REFRESH_LIST)
  ) u_refresh (
    .csr_num (csr_num),
    .hit     (refresh_hit)
  );

  // ---------------- next-state logic ----------------
  logic              accepted;
  logic              modifies;
  logic              priv_fault;
  logic              ro_fault;
  logic              commit;
  logic              wb_en_d;
  logic              exc_valid_d;
  logic [EXC_W-1:0]  exc_code_d;
  logic [DATA_W-1:0] ret_val;
  logic              refresh_d;

  always_comb begin
    accepted    = (op != OP_NONE);
    modifies    = (op == OP_WRITE) || (op == OP_XCHG);
    priv_fault  = accepted && user_mode;
    ro_fault    = accepted && !user_mode && csr_defined && csr_readonly && modifies;
    exc_valid_d = priv_fault || ro_fault;
    commit      = accepted && !exc_valid_d;
    exc_code_d  = priv_fault ? EXC_PRIV : (ro_fault ? EXC_ILLEGAL : EXC_NONE);
    ret_val     = csr_defined ? csr_rdata : '0;
    wb_en_d     = commit && (rd_idx != '0);
    csr_we      = commit && csr_defined && modifies;
    refresh_d   = csr_we && refresh_hit;
  end

  assign csr_addr  = csr_num;
  assign csr_wdata = merged;

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wb_en       <= 1'b0;
      exc_valid   <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      wb_en       <= wb_en_d;
      exc_valid   <= exc_valid_d;
      refresh_req <= refresh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wb_idx   <= '0;
      wb_data  <= '0;
      exc_code <= EXC_NONE;
    end else if (accepted) begin
      wb_idx   <= rd_idx;
      wb_data  <= ret_val;
      exc_code <= exc_code_d;
    end
  end

  // ---------------- assertions ----------------
  p_user_no_write_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op != OP_NONE && user_mode) |-> !csr_we);

  p_ro_no_write_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    csr_we |-> (csr_defined && !csr_readonly));

  p_read_no_write_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_READ) |-> !csr_we);

  p_undef_zero_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wb_en && !$past(csr_defined)) |-> (wb_data == '0));

  p_refresh_after_write_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    refresh_req |-> $past(csr_we));

  p_no_r0_wb_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    wb_en |-> (wb_idx != '0));

  p_exc_excl_wb_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    exc_valid |-> !wb_en);

  p_exc_from_insn_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    exc_valid |-> $past(insn_valid));

endmodule

// File: tb/csr_exec_unit_tb.sv
module csr_exec_unit_tb;

  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          insn_valid;
  logic [31:0]   insn;
  logic          user_mode;
  logic [DW-1:0] rd_value, rj_value, csr_rdata;
  logic          csr_defined, csr_readonly;
  logic [13:0]   csr_addr;
  logic          csr_we;
  logic [DW-1:0] csr_wdata;
  logic          wb_en;
  logic [4:0]    wb_idx;
  logic [DW-1:0] wb_data;
  logic          exc_valid;
  logic [5:0]    exc_code;
  logic          refresh_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  csr_exec_unit #(.DATA_W(DW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_valid   (insn_valid),
    .insn         (insn),
    .user_mode    (user_mode),
    .rd_value     (rd_value),
    .rj_value     (rj_value),
    .csr_rdata    (csr_rdata),
    .csr_defined  (csr_defined),
    .csr_readonly (csr_readonly),
    .csr_addr     (csr_addr),
    .csr_we       (csr_we),
    .csr_wdata    (csr_wdata),
    .wb_en        (wb_en),
    .wb_idx       (wb_idx),
    .wb_data      (wb_data),
    .exc_valid    (exc_valid),
    .exc_code     (exc_code),
    .refresh_req  (refresh_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [13:0] num,
                                     input logic [4:0] rj, input logic [4:0] rd);
    return {8'h04, num, rj, rd};
  endfunction

  function automatic bit on_refresh_list(input logic [13:0] num);
    return (num == 14'h000) || (num == 14'h002) || (num == 14'h005) || (num == 14'h018);
  endfunction

  // drive one vector, check the register port in-cycle and the registered results next cycle
  task automatic apply(input logic [31:0] ins, input logic v, input logic usr,
                       input logic [DW-1:0] rdv, input logic [DW-1:0] rjv,
                       input logic [DW-1:0] rdat, input logic def, input logic ro);
    logic grp, mods, e_we, e_wb, e_exc, e_ref;
    logic [1:0]    kind;
    logic [DW-1:0] e_wd, e_wbd;
    logic [5:0]    e_code;
    string tag;
    @(negedge clk);
    insn = ins; insn_valid = v; user_mode = usr;
    rd_value = rdv; rj_value = rjv; csr_rdata = rdat;
    csr_defined = def; csr_readonly = ro;

    grp  = v && (ins[31:24] == 8'h04);
    kind = (ins[9:5] == 5'd0) ? 2'd0 : ((ins[9:5] == 5'd1) ? 2'd1 : 2'd2);
    mods = (kind != 2'd0);
    e_we = 0; e_wd = '0; e_wb = 0; e_wbd = '0; e_exc = 0; e_code = 6'h00; e_ref = 0;
    tag  = "R1";
    if (grp) begin
      if (usr) begin
        e_exc = 1; e_code = 6'h0E; tag = "R5";
      end else if (def && ro && mods) begin
        e_exc = 1; e_code = 6'h0D; tag = "R7";
      end else begin
        tag   = !def ? "R6" : (kind == 2'd0 ? "R2" : (kind == 2'd1 ? "R3" : "R4"));
        e_wbd = def ? rdat : '0;
        e_wb  = (ins[4:0] != 5'd0);
        if (def && mods) begin
          e_we  = 1;
          e_wd  = (kind == 2'd1) ? rdv : ((rdv & rjv) | (rdat & ~rjv));
          e_ref = on_refresh_list(ins[23:10]);
        end
      end
    end

    #2;
    chk("R1", "csr_addr", DW'(csr_addr), DW'(ins[23:10]));
    chk(tag, "csr_we", DW'(csr_we), DW'(e_we));
    if (e_we) chk(tag, "csr_wdata", csr_wdata, e_wd);

    @(posedge clk);
    #2;
    chk(ins[4:0] == 5'd0 ? "R9" : tag, "wb_en", DW'(wb_en), DW'(e_wb));
    if (e_wb) begin
      chk(tag, "wb_data", wb_data, e_wbd);
      chk(tag, "wb_idx", DW'(wb_idx), DW'(ins[4:0]));
    end
    chk(tag, "exc_valid", DW'(exc_valid), DW'(e_exc));
    if (e_exc) chk(tag, "exc_code", DW'(exc_code), DW'(e_code));
    chk("R8", "refresh_req", DW'(refresh_req), DW'(e_ref));
    chk("R10", "exc_and_wb", DW'(exc_valid && wb_en), '0);
  endtask

  function automatic logic [DW-1:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] ones;
    ones = '1;
    void'($urandom(32'h00C5_A17E));
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; user_mode = 1'b0;
    rd_value = '0; rj_value = '0; csr_rdata = '0; csr_defined = 1'b0; csr_readonly = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R10", "reset wb_en", DW'(wb_en), '0);
    chk("R10", "reset exc_valid", DW'(exc_valid), '0);
    chk("R10", "reset refresh_req", DW'(refresh_req), '0);

    // directed corners
    apply(mk(14'h005, 5'd0, 5'd3), 1, 0, 64'h1, 64'h2, 64'hAAAA_5555_0000_FFFF, 1, 0); // R2 read of refresh reg, no refresh
    apply(mk(14'h018, 5'd1, 5'd4), 1, 0, 64'h3FF, 64'h0, 64'h77, 1, 0);             // R3 + R8
    apply(mk(14'h003, 5'd1, 5'd4), 1, 0, 64'h3FF, 64'h0, 64'h77, 1, 0);             // R8 near miss
    apply(mk(14'h010, 5'd7, 5'd6), 1, 0, 64'hFFFF_0000_FFFF_0000, 64'h0, 64'h1234_5678_9ABC_DEF0, 1, 0); // R4 zero mask
    apply(mk(14'h010, 5'd2, 5'd6), 1, 0, 64'hFFFF_0000_FFFF_0000, ones, 64'h1234_5678_9ABC_DEF0, 1, 0);  // R4 full mask
    apply(mk(14'h000, 5'd9, 5'd6), 1, 0, 64'h0F0F, 64'h00FF, 64'hF0F0, 1, 0);       // R4 + R8
    apply(mk(14'h020, 5'd5, 5'd8), 1, 0, 64'h5, 64'h7, 64'h99, 0, 0);               // R6 undefined exchange
    apply(mk(14'h021, 5'd0, 5'd8), 1, 0, 64'h5, 64'h7, 64'h99, 0, 1);               // R6 undefined read
    apply(mk(14'h022, 5'd0, 5'd9), 1, 0, 64'h5, 64'h7, 64'hBEEF, 1, 1);             // R7 ro read allowed
    apply(mk(14'h022, 5'd1, 5'd9), 1, 0, 64'h5, 64'h7, 64'hBEEF, 1, 1);             // R7 ro write trap
    apply(mk(14'h002, 5'd3, 5'd9), 1, 1, 64'h5, 64'h7, 64'hBEEF, 0, 1);             // R5 user beats undefined/ro
    apply(mk(14'h002, 5'd1, 5'd0), 1, 0, 64'h55, 64'h0, 64'h66, 1, 0);              // R9 write with rd r0
    apply({8'h05, 14'h002, 5'd1, 5'd2}, 1, 0, 64'h1, 64'h1, 64'h1, 1, 0);           // R1 outside group
    apply(mk(14'h002, 5'd1, 5'd2), 0, 0, 64'h1, 64'h1, 64'h1, 1, 0);                // R1 not valid
    apply(mk(14'h011, 5'd1, 5'd2), 1, 1, 64'h1, 64'h1, 64'h1, 1, 0);                // R5 exception
    apply(32'h0, 0, 0, 64'h0, 64'h0, 64'h0, 0, 0);                                  // R10 exception lasts one cycle

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins;
      logic [13:0] num;
      logic [4:0]  rj;
      int unsigned r;
      r = $urandom % 8;
      num = (r == 0) ? 14'h000 : (r == 1) ? 14'h002 : (r == 2) ? 14'h005 :
            (r == 3) ? 14'h018 : (r == 4) ? 14'h003 : 14'($urandom);
      r  = $urandom % 4;
      rj = (r == 0) ? 5'd0 : (r == 1) ? 5'd1 : 5'($urandom);
      ins = mk(num, rj, 5'($urandom));
      if ($urandom % 10 == 0) begin
        ins = $urandom;
        if (ins[31:24] == 8'h04) ins[31] = 1'b1;
      end
      apply(ins, ($urandom % 8) != 0, ($urandom % 5) == 0, r64(), r64(), r64(),
            ($urandom % 5) != 0, ($urandom % 5) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule